// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt Pulse Shaping

This block is an 8-bit down-counter for a real-time-clock subsystem. It runs from an enable strobe that arrives at 32.768 kHz. From that strobe it derives five source rates without generating any clock, and it decrements the programmed count once per source tick. When the count runs out, the counter reloads the programmed value and keeps going. Every expiry sets a countdown flag and asserts an active-low interrupt request.

The request has two modes. In level mode it follows the flag, gated by the interrupt enable. In pulse mode it goes low for a computed width. At the fastest rate, and at 64 Hz with a count of one, that width is tied to the source period. At the slower rates it is chosen by a 3-bit width code, in steps of 15.625 ms. If the chosen width is longer than the timer period, the width falls back to a single step. Clearing the flag ends a pulse at once, so software that has serviced the event does not have to wait for the pulse to finish.

Top module: `cdt_timer`

## Requirements
- R1: After reset the countdown flag is low and the interrupt output is high.
- R2: A programmed count of zero halts the timer: no expiry happens, the flag stays low and the interrupt output stays high.
- R3: `src_sel` picks the source rate: 0 = 4096 Hz, 1 = 64 Hz, 2 = 1 Hz, 3 = one per minute, and 4 to 7 = one per hour. With a tick every clock, one source period is 8, 512, 32768, 1966080 or 117964800 clocks. Each expiry reloads the programmed count, so successive expiries are spaced by count × source period.
- R4: At 4096 Hz in pulse mode the interrupt stays low for 4 clocks when the count is 1, and for 8 clocks when the count is greater than 1.
- R5: At 64 Hz in pulse mode with a count of 1, the interrupt stays low for 256 clocks, which is half a source period.
- R6: At 64 Hz and the slower rates in pulse mode, width code N gives a low time of (N+1) × 512 clocks, provided the count is at least N+1.
- R7: At 64 Hz with a count greater than 1 but smaller than N+1, the low time falls back to 512 clocks.
- R8: Pulsing `flag_clr` clears the flag and releases the interrupt output on the next clock edge, even in the middle of a pulse.
- R9: In level mode (`pulse_mode` = 0) the interrupt output is low exactly while the flag and `int_en` are both set. Dropping `int_en` releases the output at once and leaves the flag set.
- R10: Enabling the timer resets the rate divider. The programmed count is loaded on the first source tick, so at 4096 Hz the first expiry comes at the 8×(count+1)+1-th clock edge, counting the edge that samples the enable as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | 32.768 kHz enable strobe, one clock wide |
| tmr_en | input | 1 | Timer run enable |
| load_we | input | 1 | Write strobe for the programmed count |
| load_val | input | 8 | Programmed count |
| src_sel | input | 3 | Source rate select |
| pulse_mode | input | 1 | 1 = pulsed interrupt, 0 = level interrupt |
| int_en | input | 1 | Interrupt output enable |
| width_code | input | 3 | Pulse width code N, (N+1) × 15.625 ms |
| flag_clr | input | 1 | Clear strobe for the countdown flag |
| cd_flag | output | 1 | Countdown flag, set on every expiry |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong value in the rate divider or the count register shows up as a misplaced falling edge on `irq_n`. The error is visible within one timer period, and the first expiry after enable pins down the divider phase to the exact edge. A wrong width selection or a stuck pulse counter changes how many clocks the output stays low, so it is caught on the first pulse. Flag or gating faults show as an output that does not release within one clock after a clear or after the enable drops.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic [2:0] {
        SRC_4K  = 3'd0,
        SRC_64  = 3'd1,
        SRC_1   = 3'd2,
        SRC_MIN = 3'd3,
        SRC_HR  = 3'd4
    } src_e;

    typedef struct packed {
        logic s4k;
        logic s64;
        logic s1;
        logic smin;
        logic shr;
    } src_strb_t;

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
    import cdt_pkg::*;
#(
    parameter int PRE_W     = 15,
    parameter int FAST_BITS = 3,
    parameter int MID_BITS  = 9,
    parameter int SUB       = 60
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      restart,
    output src_strb_t strb
);
    localparam int SW = $clog2(SUB);
    localparam logic [SW-1:0] LAST = SW'(SUB - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SW-1:0]    sec;
        logic [SW-1:0]    mn;
    } pre_t;

    pre_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        strb    = '0;
        if (restart) begin
            state_d = '0;
        end else if (tick) begin
            state_d.pre = state_q.pre + 1'b1;
            strb.s4k    = &state_q.pre[FAST_BITS-1:0];
            strb.s64    = &state_q.pre[MID_BITS-1:0];
            strb.s1     = &state_q.pre;
            if (strb.s1) begin
                if (state_q.sec == LAST) begin
                    state_d.sec = '0;
                    strb.smin   = 1'b1;
                    if (state_q.mn == LAST) begin
                        state_d.mn = '0;
                        strb.shr   = 1'b1;
                    end else begin
                        state_d.mn = state_q.mn + 1'b1;
                    end
                end else begin
                    state_d.sec = state_q.sec + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             tmr_en,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic             restart,
    output logic             expire,
    output logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             pend_val
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             pend;
        logic             en;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = tmr_en;
        restart = tmr_en && !st_q.en;
        expire  = 1'b0;
        if (tmr_en && st_q.en && src_tick) begin
            if (st_q.pend) begin
                st_d.cnt  = st_q.reload;
                st_d.pend = 1'b0;
            end else if (st_q.cnt == CNT_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = st_q.reload;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (load_we) begin
            st_d.reload = load_val;
            st_d.pend   = 1'b1;
        end
        if (restart) st_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_val = st_q.reload;
    assign cnt_val    = st_q.cnt;
    assign pend_val   = st_q.pend;

endmodule

// File: rtl/cdt_pulse.sv
module cdt_pulse
    import cdt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WCODE_W   = 3,
    parameter int FAST_BITS = 3,
    parameter int MID_BITS  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               expire,
    input  logic               flag_clr,
    input  logic [2:0]         src_sel,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic [WCODE_W-1:0] width_code,
    input  logic               pulse_mode,
    input  logic               int_en,
    output logic               flag,
    output logic               irq_n
);
    localparam int PW_W = MID_BITS + WCODE_W + 1;
    localparam int P4K  = 1 << FAST_BITS;
    localparam int P64  = 1 << MID_BITS;

    typedef struct packed {
        logic            flag;
        logic            active;
        logic [PW_W-1:0] pw;
    } pls_t;

    pls_t ps_d, ps_q;
    logic [WCODE_W:0] nplus;
    logic [PW_W-1:0]  width;
    logic [PW_W-1:0]  code_w;

    always_comb begin
        nplus  = {1'b0, width_code} + 1'b1;
        code_w = PW_W'(nplus) << MID_BITS;
        case (src_e'(src_sel))
            SRC_4K: width = (reload_val == CNT_W'(1)) ? PW_W'(P4K / 2) : PW_W'(P4K);
            SRC_64: begin
                if (reload_val == CNT_W'(1))         width = PW_W'(P64 / 2);
                else if (reload_val < CNT_W'(nplus)) width = PW_W'(P64);
                else                                 width = code_w;
            end
            default: width = code_w;
        endcase
    end

    always_comb begin
        ps_d = ps_q;
        if (tick && ps_q.active) begin
            if (ps_q.pw == PW_W'(1)) ps_d.active = 1'b0;
            else                     ps_d.pw     = ps_q.pw - 1'b1;
        end
        if (flag_clr) begin
            ps_d.flag   = 1'b0;
            ps_d.active = 1'b0;
        end
        if (expire) begin
            ps_d.flag   = 1'b1;
            ps_d.active = 1'b1;
            ps_d.pw     = width;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign flag  = ps_q.flag;
    assign irq_n = pulse_mode ? !(ps_q.active && int_en) : !(ps_q.flag && int_en);

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WCODE_W   = 3,
    parameter int PRE_W     = 15,
    parameter int FAST_BITS = 3,
    parameter int MID_BITS  = 9,
    parameter int SUB       = 60
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_32k,
    input  logic               tmr_en,
    input  logic               load_we,
    input  logic [CNT_W-1:0]   load_val,
    input  logic [2:0]         src_sel,
    input  logic               pulse_mode,
    input  logic               int_en,
    input  logic [WCODE_W-1:0] width_code,
    input  logic               flag_clr,
    output logic               cd_flag,
    output logic               irq_n
);
    src_strb_t        strb;
    logic             restart;
    logic             src_tick;
    logic             expire;
    logic [CNT_W-1:0] reload_w;
    logic [CNT_W-1:0] cnt_w;
    logic             pend_w;

    cdt_prescale #(
        .PRE_W(PRE_W), .FAST_BITS(FAST_BITS), .MID_BITS(MID_BITS), .SUB(SUB)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .restart(restart), .strb(strb)
    );

    always_comb begin
        case (src_e'(src_sel))
            SRC_4K:  src_tick = strb.s4k;
            SRC_64:  src_tick = strb.s64;
            SRC_1:   src_tick = strb.s1;
            SRC_MIN: src_tick = strb.smin;
            default: src_tick = strb.shr;
        endcase
    end

    cdt_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .tmr_en(tmr_en),
        .load_we(load_we), .load_val(load_val), .restart(restart),
        .expire(expire), .reload_val(reload_w), .cnt_val(cnt_w), .pend_val(pend_w)
    );

    cdt_pulse #(
        .CNT_W(CNT_W), .WCODE_W(WCODE_W), .FAST_BITS(FAST_BITS), .MID_BITS(MID_BITS)
    ) u_pls (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .expire(expire),
        .flag_clr(flag_clr), .src_sel(src_sel), .reload_val(reload_w),
        .width_code(width_code), .pulse_mode(pulse_mode), .int_en(int_en),
        .flag(cd_flag), .irq_n(irq_n)
    );

endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             expire,
    input logic             flag_clr,
    input logic             pulse_mode,
    input logic             int_en,
    input logic             cd_flag,
    input logic             irq_n,
    input logic [CNT_W-1:0] cnt,
    input logic             pend
);
    // R2: an empty count with no pending load never expires
    assert_zero_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !pend) |-> !expire);

    // R3: every expiry leaves the flag set
    assert_flag_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> cd_flag);

    // R4: an expiry in pulse mode with the output enabled drives the request low
    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && pulse_mode && int_en) |=> !irq_n);

    // R8: a clear with no competing expiry releases the request next cycle
    assert_clear_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !expire) |=> (irq_n && !cd_flag));

    // R9: in level mode the flag stays set until cleared
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flag && !flag_clr) |=> cd_flag);

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .expire(expire), .flag_clr(flag_clr),
    .pulse_mode(pulse_mode), .int_en(int_en), .cd_flag(cd_flag),
    .irq_n(irq_n), .cnt(cnt_w), .pend(pend_w)
);

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int WAIT_MAX   = 80000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b1;
    logic       tmr_en = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_val = '0;
    logic [2:0] src_sel = '0;
    logic       pulse_mode = 1'b0;
    logic       int_en = 1'b0;
    logic [2:0] width_code = '0;
    logic       flag_clr = 1'b0;
    logic       cd_flag;
    logic       irq_n;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    cdt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .tmr_en(tmr_en),
        .load_we(load_we), .load_val(load_val), .src_sel(src_sel),
        .pulse_mode(pulse_mode), .int_en(int_en), .width_code(width_code),
        .flag_clr(flag_clr), .cd_flag(cd_flag), .irq_n(irq_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic configure(input int src, input int cnt, input int code, input bit pm);
        @(negedge clk);
        tmr_en = 1'b0; flag_clr = 1'b1; load_we = 1'b1; load_val = 8'(cnt);
        src_sel = 3'(src); width_code = 3'(code); pulse_mode = pm; int_en = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; load_we = 1'b0; tmr_en = 1'b1;
    endtask

    // counts negedge samples until irq_n is low; returns 0 on timeout
    task automatic wait_fall(output int n);
        n = 0;
        for (int i = 1; i <= WAIT_MAX; i++) begin
            @(negedge clk);
            if (!irq_n) begin n = i; break; end
        end
    endtask

    // called right after a low sample: returns low width and fall-to-fall period
    task automatic measure(output int w, output int p);
        w = 1; p = 1;
        for (int i = 0; i < WAIT_MAX; i++) begin
            @(negedge clk);
            p++;
            if (irq_n) break;
            w++;
        end
        for (int i = 0; i < WAIT_MAX; i++) begin
            @(negedge clk);
            if (!irq_n) break;
            p++;
        end
    endtask

    task automatic run_pulse(input string req, input int src, input int cnt, input int code,
                             input int exp_w, input int exp_p);
        int n, w, p;
        configure(src, cnt, code, 1'b1);
        wait_fall(n);
        check(n != 0, {req, " fall seen"}, n, 1);
        measure(w, p);
        check(w == exp_w, {req, " width"}, w, exp_w);
        check(p == exp_p, {req, " period"}, p, exp_p);
    endtask

    task automatic t_reset();
        #1;
        check(cd_flag == 1'b0, "R1 flag", int'(cd_flag), 0);
        check(irq_n == 1'b1, "R1 irq_n", int'(irq_n), 1);
    endtask

    task automatic t_zero_halt();
        int n;
        configure(0, 0, 0, 1'b1);
        wait_fall(n);
        check(n == 0, "R2 no expiry on zero", n, 0);
        check(cd_flag == 1'b0, "R2 flag stays low", int'(cd_flag), 0);
    endtask

    task automatic t_restart();
        int n;
        configure(0, 3, 0, 1'b1);
        wait_fall(n);
        check(n == 33, "R10 first expiry edge", n, 33);
        check(cd_flag == 1'b1, "R10 flag set", int'(cd_flag), 1);
    endtask

    task automatic t_clear();
        int n;
        configure(1, 4, 2, 1'b1);
        wait_fall(n);
        repeat (10) @(negedge clk);
        check(irq_n == 1'b0, "R8 pulse still low", int'(irq_n), 0);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check(irq_n == 1'b1, "R8 released next edge", int'(irq_n), 1);
        check(cd_flag == 1'b0, "R8 flag cleared", int'(cd_flag), 0);
    endtask

    task automatic t_level();
        int n;
        configure(0, 2, 0, 1'b0);
        wait_fall(n);
        repeat (20) @(negedge clk);
        check(irq_n == 1'b0, "R9 level held", int'(irq_n), 0);
        int_en = 1'b0;
        #1;
        check(irq_n == 1'b1, "R9 released by enable", int'(irq_n), 1);
        check(cd_flag == 1'b1, "R9 flag kept", int'(cd_flag), 1);
        @(negedge clk);
        int_en = 1'b1;
        #1;
        check(irq_n == 1'b0, "R9 reasserted", int'(irq_n), 0);
    endtask

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_zero_halt();
        t_restart();
        run_pulse("R4 4096Hz count1", 0, 1, 0, 4, 8);
        run_pulse("R4 4096Hz count3", 0, 3, 5, 8, 24);
        run_pulse("R5 64Hz count1", 1, 1, 3, 256, 512);
        run_pulse("R6 64Hz count4 code2", 1, 4, 2, 1536, 2048);
        run_pulse("R7 64Hz count2 code5", 1, 2, 5, 512, 1024);
        t_clear();
        t_level();
        run_pulse("R3 R6 1Hz count1 code0", 2, 1, 0, 512, 32768);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule